// File: doc/BRIEF.md
# Reliability-Aware Tier Placement Selector

This block watches a stream of memory access events for a small, fixed set of tracked pages. It decides which of those pages belong in a fast memory tier that is less well protected and which belong in a slower tier with stronger protection. Each event names a page and says whether it is a read or a write. For each page the block keeps a read count and a write count for the current interval.

When an interval tick arrives, the block takes a snapshot of its decision and clears its counters. Pages are ranked by hotness, which is reads plus writes. A page whose write-weighted risk (writes squared over reads) is above a programmable limit is never placed in the fast tier. The hottest remaining pages, up to the capacity of the fast tier, become the fast-tier set. All other pages go to the reliable tier.

The block then emits one migration command per accepted handshake. A command is a page index and a direction. It emits commands only for pages whose current tier differs from the chosen one. It pulses a done flag once the last command of the interval has been accepted. Moving the data and remapping addresses are left to the surrounding system.

Top module: `migsel_top`

## Requirements
- R1: After reset, all pages are in the reliable tier, `cmdValid` and `intervalDone` are low, and an interval with no accesses produces no commands.
- R2: A page's hotness is its reads plus writes since the previous accepted tick. The fast-tier set is made of the hottest eligible pages, and a tie in hotness goes to the lower page index. A page with zero hotness is never eligible.
- R3: Each read counter and each write counter stops at 2^CNT_W-1 and never wraps. Pages that saturate therefore compare as equal in hotness.
- R4: A page is ineligible for the fast tier when writes×writes > riskLimit×reads. This comparison is made without a divider. A page with writes but no reads is therefore always ineligible.
- R5: No more than FAST_SLOTS pages are in the fast tier at any time, and no more than FAST_SLOTS promotions are issued per interval.
- R6: After a tick, all demotions are issued first, in ascending page index. Promotions follow, also in ascending page index. `cmdPromote`=1 means move to the fast tier and 0 means move to the reliable tier. No command is issued for a page that is already in its chosen tier.
- R7: A command is accepted when `cmdValid` and `cmdReady` are both high. While `cmdValid` is high and `cmdReady` is low, `cmdPage` and `cmdPromote` hold steady.
- R8: `intervalDone` is high for exactly one cycle. It comes in the cycle after the last pending command is gone, or in the second cycle after the tick edge if there is nothing to issue. `cmdValid` is low in that cycle.
- R9: A tick sampled while idle clears every counter. An access sampled in the same cycle as that tick counts toward the new interval. A tick sampled while commands are still being issued is ignored, and accesses during that time are still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access event present this cycle |
| accPage | input | PAGE_W | Index of the accessed page |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| riskLimit | input | CNT_W | Risk threshold compared against writes squared over reads |
| intervalTick | input | 1 | Interval boundary request |
| cmdReady | input | 1 | Consumer accepts the current command |
| cmdValid | output | 1 | A migration command is presented |
| cmdPage | output | PAGE_W | Page index of the command |
| cmdPromote | output | 1 | 1 = promote to fast tier, 0 = demote to reliable tier |
| intervalDone | output | 1 | One-cycle pulse after the interval's last command |

## Verification
The hardest state to reach is a tie at the capacity boundary between saturated pages. Reaching it takes hundreds of accesses to each of several pages. The stimulus drives more than 2^CNT_W reads into three pages so that a wrapping counter would lose its rank. A tick is also sent in the middle of an issuing burst, and another arrives together with an access. Together these show that a tick during a burst is ignored and that an access in the tick cycle counts toward the next interval. Ready is throttled during a mixed demote-and-promote interval, so the command ordering and holding are seen under back-pressure.

// File: rtl/migsel_pkg.sv
package migsel_pkg;
  // Strobes from the sequencer into the datapath.
  typedef struct packed {
    logic snap;           // take the decision, clear counters
    logic accept;         // a command was accepted this cycle
    logic acceptPromote;  // direction of the accepted command
  } ctrl_strobe_t;
endpackage

// File: rtl/migsel_datapath.sv
module migsel_datapath
  import migsel_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int FAST_SLOTS = 3,
  parameter int CNT_W      = 8,
  parameter bit RISK_AWARE = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             accValid,
  input  logic [$clog2(NUM_PAGES)-1:0]     accPage,
  input  logic                             accWrite,
  input  logic [CNT_W-1:0]                 riskLimit,
  input  ctrl_strobe_t                     strobe,
  input  logic [$clog2(NUM_PAGES)-1:0]     strobePage,
  output logic [NUM_PAGES-1:0]             demMask,
  output logic [NUM_PAGES-1:0]             proMask,
  output logic [NUM_PAGES-1:0]             tierVec
);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int HOT_W  = CNT_W + 1;
  localparam int RISK_W = 2 * CNT_W;
  localparam int RANK_W = $clog2(NUM_PAGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_PAGES-1:0] hitVec;
  logic [HOT_W-1:0]     hot [NUM_PAGES];
  logic [NUM_PAGES-1:0] risky;
  logic [NUM_PAGES-1:0] cand;
  logic [NUM_PAGES-1:0] select;
  logic [NUM_PAGES-1:0] target;
  logic [NUM_PAGES-1:0] tier;

  function automatic logic [CNT_W-1:0] nextCnt(input logic [CNT_W-1:0] cur,
                                               input logic clr, input logic inc);
    if (clr)                        return CNT_W'(inc);
    else if (inc && cur != CNT_MAX) return cur + 1'b1;
    else                            return cur;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_PAGES; i++)
      hitVec[i] = accValid && (accPage == PAGE_W'(i));
  end

  generate
    if (RISK_AWARE) begin : g_dual
      logic [CNT_W-1:0] rdCnt [NUM_PAGES];
      logic [CNT_W-1:0] wrCnt [NUM_PAGES];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < NUM_PAGES; i++) begin
            rdCnt[i] <= '0;
            wrCnt[i] <= '0;
          end
        end else begin
          for (int i = 0; i < NUM_PAGES; i++) begin
            rdCnt[i] <= nextCnt(rdCnt[i], strobe.snap, hitVec[i] && !accWrite);
            wrCnt[i] <= nextCnt(wrCnt[i], strobe.snap, hitVec[i] && accWrite);
          end
        end
      end

      // Cross-multiplied risk test: wr*wr > limit*rd
      always_comb begin
        for (int i = 0; i < NUM_PAGES; i++) begin
          logic [RISK_W-1:0] wrSq;
          logic [RISK_W-1:0] bound;
          wrSq     = RISK_W'(wrCnt[i]) * RISK_W'(wrCnt[i]);
          bound    = RISK_W'(riskLimit) * RISK_W'(rdCnt[i]);
          risky[i] = wrSq > bound;
          hot[i]   = HOT_W'(rdCnt[i]) + HOT_W'(wrCnt[i]);
        end
      end
    end else begin : g_single
      logic [CNT_W-1:0] totCnt [NUM_PAGES];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < NUM_PAGES; i++) totCnt[i] <= '0;
        end else begin
          for (int i = 0; i < NUM_PAGES; i++)
            totCnt[i] <= nextCnt(totCnt[i], strobe.snap, hitVec[i]);
        end
      end

      always_comb begin
        for (int i = 0; i < NUM_PAGES; i++) begin
          hot[i]   = HOT_W'(totCnt[i]);
          risky[i] = 1'b0;
        end
      end
    end
  endgenerate

  // Rank each eligible page by how many eligible pages beat it.
  always_comb begin
    for (int i = 0; i < NUM_PAGES; i++) begin
      logic [RANK_W-1:0] beaten;
      cand[i] = (hot[i] != '0) && !risky[i];
      beaten  = '0;
      for (int j = 0; j < NUM_PAGES; j++) begin
        if (j != i && (hot[j] != '0) && !risky[j] &&
            ((hot[j] > hot[i]) || ((hot[j] == hot[i]) && (j < i))))
          beaten = beaten + 1'b1;
      end
      select[i] = cand[i] && (beaten < RANK_W'(FAST_SLOTS));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= '0;
      tier   <= '0;
    end else begin
      if (strobe.snap) target <= select;
      if (strobe.accept) tier[strobePage] <= strobe.acceptPromote;
    end
  end

  assign demMask = tier & ~target;
  assign proMask = ~tier & target;
  assign tierVec = tier;
endmodule

// File: rtl/migsel_control.sv
module migsel_control
  import migsel_pkg::*;
#(
  parameter int NUM_PAGES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         intervalTick,
  input  logic                         cmdReady,
  input  logic [NUM_PAGES-1:0]         demMask,
  input  logic [NUM_PAGES-1:0]         proMask,
  output logic                         cmdValid,
  output logic [$clog2(NUM_PAGES)-1:0] cmdPage,
  output logic                         cmdPromote,
  output logic                         intervalDone,
  output ctrl_strobe_t                 strobe
);
  localparam int PAGE_W = $clog2(NUM_PAGES);

  typedef enum logic {ST_IDLE, ST_ISSUE} state_t;
  state_t state;

  function automatic logic [PAGE_W-1:0] lowIdx(input logic [NUM_PAGES-1:0] m);
    logic [PAGE_W-1:0] r;
    r = '0;
    for (int k = NUM_PAGES - 1; k >= 0; k--)
      if (m[k]) r = PAGE_W'(k);
    return r;
  endfunction

  logic anyDem;
  logic anyPro;

  always_comb begin
    anyDem     = |demMask;
    anyPro     = |proMask;
    cmdValid   = (state == ST_ISSUE) && (anyDem || anyPro);
    cmdPromote = !anyDem;
    cmdPage    = anyDem ? lowIdx(demMask) : lowIdx(proMask);
    strobe.snap          = (state == ST_IDLE) && intervalTick;
    strobe.accept        = cmdValid && cmdReady;
    strobe.acceptPromote = cmdPromote;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      intervalDone <= 1'b0;
    end else begin
      intervalDone <= 1'b0;
      case (state)
        ST_IDLE:  if (intervalTick) state <= ST_ISSUE;
        ST_ISSUE: if (!cmdValid) begin
                    state        <= ST_IDLE;
                    intervalDone <= 1'b1;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/migsel_top.sv
module migsel_top
  import migsel_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int FAST_SLOTS = 3,
  parameter int CNT_W      = 8,
  parameter bit RISK_AWARE = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         accValid,
  input  logic [$clog2(NUM_PAGES)-1:0] accPage,
  input  logic                         accWrite,
  input  logic [CNT_W-1:0]             riskLimit,
  input  logic                         intervalTick,
  input  logic                         cmdReady,
  output logic                         cmdValid,
  output logic [$clog2(NUM_PAGES)-1:0] cmdPage,
  output logic                         cmdPromote,
  output logic                         intervalDone
);
  ctrl_strobe_t         strobe;
  logic [NUM_PAGES-1:0] demMask;
  logic [NUM_PAGES-1:0] proMask;
  logic [NUM_PAGES-1:0] tierVec;

  migsel_datapath #(
    .NUM_PAGES(NUM_PAGES), .FAST_SLOTS(FAST_SLOTS),
    .CNT_W(CNT_W), .RISK_AWARE(RISK_AWARE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accPage(accPage),
    .accWrite(accWrite), .riskLimit(riskLimit), .strobe(strobe),
    .strobePage(cmdPage), .demMask(demMask), .proMask(proMask),
    .tierVec(tierVec)
  );

  migsel_control #(.NUM_PAGES(NUM_PAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .intervalTick(intervalTick), .cmdReady(cmdReady),
    .demMask(demMask), .proMask(proMask), .cmdValid(cmdValid),
    .cmdPage(cmdPage), .cmdPromote(cmdPromote), .intervalDone(intervalDone),
    .strobe(strobe)
  );
endmodule

// File: rtl/migsel_checker.sv
module migsel_checker #(
  parameter int NUM_PAGES  = 8,
  parameter int FAST_SLOTS = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cmdValid,
  input logic                         cmdReady,
  input logic [$clog2(NUM_PAGES)-1:0] cmdPage,
  input logic                         cmdPromote,
  input logic                         intervalDone,
  input logic [NUM_PAGES-1:0]         tierVec,
  input logic [NUM_PAGES-1:0]         demMask
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdPage) && $stable(cmdPromote));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    intervalDone |=> !intervalDone);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    intervalDone |-> !cmdValid);

  p_capacity_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tierVec) <= FAST_SLOTS);

  p_demote_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdPromote |-> demMask == '0);

  p_no_redundant_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> tierVec[cmdPage] == !cmdPromote);
endmodule

bind migsel_top migsel_checker #(.NUM_PAGES(NUM_PAGES), .FAST_SLOTS(FAST_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdPage(cmdPage), .cmdPromote(cmdPromote), .intervalDone(intervalDone),
  .tierVec(tierVec), .demMask(demMask)
);

// File: tb/sim_migsel_top.sv
module sim_migsel_top;
  localparam int NP = 8;
  localparam int NS = 3;
  localparam int CW = 8;
  localparam int PW = $clog2(NP);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [PW-1:0] accPage = '0;
  logic accWrite = 1'b0;
  logic [CW-1:0] riskLimit = 8'd4;
  logic intervalTick = 1'b0;
  logic cmdReady = 1'b1;
  logic cmdValid;
  logic [PW-1:0] cmdPage;
  logic cmdPromote;
  logic intervalDone;

  always #10 clk = ~clk;

  migsel_top #(.NUM_PAGES(NP), .FAST_SLOTS(NS), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accPage(accPage),
    .accWrite(accWrite), .riskLimit(riskLimit), .intervalTick(intervalTick),
    .cmdReady(cmdReady), .cmdValid(cmdValid), .cmdPage(cmdPage),
    .cmdPromote(cmdPromote), .intervalDone(intervalDone)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  int cyc = 0;
  bit slowReady = 1'b0;
  bit finished = 1'b0;

  // Reference model
  int  mRd [NP];
  int  mWr [NP];
  bit  mTier [NP];
  bit  mBusy = 0;
  bit  mDone = 0;
  int  qPage [$];
  bit  qPro [$];
  int  doneCnt = 0;
  int  promoCnt = 0;
  string obs = "";

  task automatic check(bit ok, string req, string what, string act, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  function automatic void buildQueue();
    bit sel [NP];
    bit elig [NP];
    for (int i = 0; i < NP; i++) begin
      int h = mRd[i] + mWr[i];
      sel[i] = 0;
      elig[i] = (h > 0) && !(mWr[i] * mWr[i] > int'(riskLimit) * mRd[i]);
    end
    for (int n = 0; n < NS; n++) begin
      int best = -1;
      int bestHot = 0;
      for (int i = 0; i < NP; i++)
        if (elig[i] && !sel[i] && (mRd[i] + mWr[i]) > bestHot) begin
          best = i; bestHot = mRd[i] + mWr[i];
        end
      if (best >= 0) sel[best] = 1;
    end
    qPage.delete(); qPro.delete();
    for (int i = 0; i < NP; i++)
      if (mTier[i] && !sel[i]) begin qPage.push_back(i); qPro.push_back(0); end
    for (int i = 0; i < NP; i++)
      if (!mTier[i] && sel[i]) begin qPage.push_back(i); qPro.push_back(1); end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NP; i++) begin mRd[i] = 0; mWr[i] = 0; mTier[i] = 0; end
      mBusy = 0; mDone = 0; qPage.delete(); qPro.delete();
    end else begin
      bit wasBusy;
      wasBusy = mBusy;
      mDone = 0;
      if (wasBusy) begin
        if (qPage.size() > 0) begin
          if (cmdReady) begin
            mTier[qPage[0]] = qPro[0];
            void'(qPage.pop_front());
            void'(qPro.pop_front());
          end
        end else begin
          mBusy = 0; mDone = 1;
        end
      end
      if (intervalTick && !wasBusy) begin
        buildQueue();
        for (int i = 0; i < NP; i++) begin mRd[i] = 0; mWr[i] = 0; end
        mBusy = 1;
      end
      if (accValid) begin
        if (accWrite) begin if (mWr[accPage] < CMAX) mWr[accPage]++; end
        else          begin if (mRd[accPage] < CMAX) mRd[accPage]++; end
      end
    end
  end

  always @(posedge clk) cmdReady <= slowReady ? (cyc % 3 == 0) : 1'b1;

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expV;
      bit ok;
      expV = mBusy && (qPage.size() > 0);
      ok = (cmdValid == expV) && (intervalDone == mDone);
      if (ok && expV) ok = (cmdPage == PW'(qPage[0])) && (cmdPromote == qPro[0]);
      check(ok, curReq, "cycle compare",
            $sformatf("v%0d p%0d d%0b done%0b", cmdValid, cmdPage, cmdPromote, intervalDone),
            expV ? $sformatf("v1 p%0d d%0b done%0b", qPage[0], qPro[0], mDone)
                 : $sformatf("v0 done%0b", mDone));
      if (intervalDone) doneCnt++;
      if (cmdValid && cmdReady) begin
        obs = {obs, $sformatf("%s%0d", cmdPromote ? "+" : "-", cmdPage)};
        if (cmdPromote) promoCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(bit v, int pg, bit w, bit tk);
    @(negedge clk);
    accValid = v; accPage = PW'(pg); accWrite = w; intervalTick = tk;
  endtask

  task automatic hit(int pg, bit w, int n);
    for (int k = 0; k < n; k++) step(1, pg, w, 0);
    step(0, 0, 0, 0);
  endtask

  // Tick, optionally with an access in the tick cycle and a tick during issue
  task automatic runInterval(string req, string expCmds, int tickPage, bit busyTick);
    int d0;
    d0 = doneCnt; obs = ""; promoCnt = 0;
    if (tickPage >= 0) step(1, tickPage, 0, 1); else step(0, 0, 0, 1);
    if (busyTick) begin
      step(1, 7, 0, 1);
      step(1, 7, 0, 0);
    end
    step(0, 0, 0, 0);
    for (int k = 0; k < 200 && mBusy; k++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check(obs == expCmds, req, "command sequence", obs, expCmds);
    check(doneCnt == d0 + 1, "R8", "done pulses", $sformatf("%0d", doneCnt - d0), "1");
    check(promoCnt <= NS, "R5", "promotions", $sformatf("%0d", promoCnt), $sformatf("<=%0d", NS));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmdValid == 0 && intervalDone == 0, "R1", "reset outputs",
          $sformatf("%0d%0d", cmdValid, intervalDone), "00");
    rstN = 1'b1;
    @(negedge clk);

    // R1: empty interval
    curReq = "R1";
    runInterval("R1", "", -1, 0);

    // R2: hotness ranking with a tie at the capacity boundary
    curReq = "R2";
    hit(5, 0, 5); hit(2, 0, 3); hit(7, 0, 3); hit(4, 0, 3); hit(0, 0, 2);
    runInterval("R2", "+2+4+5", -1, 0);

    // R4 / R6 / R7: risk filter, demote first, back-pressure
    curReq = "R4";
    slowReady = 1;
    hit(3, 1, 10); hit(3, 0, 1);
    hit(6, 1, 4);
    hit(1, 0, 2); hit(1, 1, 2);
    hit(5, 1, 3); hit(5, 0, 3);
    hit(0, 0, 1);
    runInterval("R6", "-2-4+0+1", -1, 0);
    slowReady = 0;

    // R3: saturation makes three pages tie; lower index wins
    curReq = "R3";
    hit(6, 0, 300); hit(3, 0, 300); hit(2, 0, 260); hit(7, 0, 254);
    runInterval("R3", "-0-1-5+2+3+6", -1, 0);

    // R9: access in tick cycle and tick during issue
    curReq = "R9";
    runInterval("R9", "-2-3-6", 4, 1);
    runInterval("R9", "+4+7", -1, 0);

    // R5: every page eligible, only the hottest three go fast
    curReq = "R5";
    for (int p = 0; p < NP; p++) hit(p, 0, p + 1);
    runInterval("R5", "-4+5+6", -1, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule